// File: doc/BRIEF.md
# Associative TLB Lookup and Protection

This unit turns a 32-bit virtual address into a 29-bit physical address. It searches two fully associative translation buffers: a small one that only instruction fetches consult, and a larger unified one that every access consults. Each entry holds a virtual page number, an address-space identifier, a physical page number and attribute bits: valid, page size, shared, dirty and a two-bit protection code. A lookup compares every entry in parallel. The first entry that matches supplies the translation. A protection decode then grants read-only or read-write access, or it produces an exception code.

Requests arrive on a single-cycle strobe together with their context: write flag, instruction flag, privileged-mode bit, current identifier, single-virtual-mode bit and a probe flag. The result appears on registered outputs one cycle later. When an instruction fetch misses the instruction buffer but hits the unified buffer, the unit copies the unified entry into an instruction slot chosen by a free-running counter. The unit also advances a replacement counter for the unified buffer, which software can use as the next victim index. Entries are loaded through a plain write port.

Top module: `tlb_xlate_unit`

## Requirements
- R1: An entry takes part in a match only when its valid bit is set. The compared virtual page bits depend on the size code: 0 = 1 KB (bits 31:10), 1 = 4 KB (bits 31:12), 2 = 64 KB (bits 31:16), 3 = 1 MB (bits 31:20).
- R2: The identifier compare is skipped when the entry is shared, or when single-virtual mode and privileged mode are both set. Otherwise the entry identifier must equal the request identifier.
- R3: On success, the physical address takes the virtual offset bits below the page size and the entry's physical page bits at and above it, and is limited to 29 bits.
- R4: Data accesses search only the unified buffer. Instruction fetches use the instruction buffer when it hits, and the unified buffer otherwise. Within a buffer, the lowest-indexed matching entry wins.
- R5: An instruction fetch that misses the instruction buffer and hits the unified buffer copies the unified entry into an instruction buffer slot. Later fetches then translate even after the unified copy is invalidated.
- R6: Instruction fetches always pass in privileged mode. In user mode they need protection bit 1 set, otherwise they take a protection violation. A successful fetch grants read-only.
- R7: In privileged data access, protection codes 0 and 2 are read-only and a write to them violates. Codes 1 and 3 allow writes, but a write with the dirty bit clear raises an initial-page-write exception.
- R8: In user data access, codes 0 and 1 always violate, code 2 is read-only (a write violates), and code 3 behaves like a privileged writable page. A writable page grants read-write only when its dirty bit is set.
- R9: The replacement counter starts at 0, increases by one on every non-probe lookup, wraps from the last unified index to 0, and holds when no lookup is made.
- R10: When the boundary input is nonzero, the counter wraps to 0 on the step where it would reach the boundary. A probe lookup leaves the counter unchanged.
- R11: The exception codes are 0x040 for a read miss, 0x060 for a write miss, 0x0A0 for a read violation, 0x0C0 for a write violation and 0x080 for an initial page write. A faulting response returns address 0 and grant 0.
- R12: A probe lookup never faults. When it would fault, it returns code 0, address 0 and grant 0. When it succeeds, it returns the normal translation.
- R13: The response is valid exactly one cycle after the request strobe. Synchronous reset clears every valid bit, so each lookup misses until entries are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup strobe, one cycle per request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a store |
| req_instr | input | 1 | Access is an instruction fetch |
| req_priv | input | 1 | Privileged mode |
| req_asid | input | 8 | Current address-space identifier |
| req_sv | input | 1 | Single-virtual mode enable |
| req_probe | input | 1 | Probe lookup, suppresses exceptions and counting |
| rep_bound | input | 6 | Replacement wrap boundary, 0 = none |
| wr_en | input | 1 | Entry write strobe |
| wr_itlb | input | 1 | 1 selects the instruction buffer, 0 the unified buffer |
| wr_idx | input | 6 | Entry index (low bits used for the instruction buffer) |
| wr_vpn | input | 22 | Virtual page bits 31:10 |
| wr_asid | input | 8 | Entry identifier |
| wr_ppn | input | 19 | Physical page bits 28:10 |
| wr_valid | input | 1 | Entry valid |
| wr_size | input | 2 | Page size code |
| wr_shared | input | 1 | Entry shared, skips identifier compare |
| wr_dirty | input | 1 | Page already written |
| wr_prot | input | 2 | Protection code |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 29 | Physical address |
| rsp_rw | output | 1 | 1 = read-write grant, 0 = read-only or none |
| rsp_fault | output | 1 | Exception raised |
| rsp_code | output | 12 | Exception code, 0 when none |
| rep_count | output | 6 | Replacement counter |

## Verification
Every lookup result, including the address, grant, fault and code, is registered at the edge that samples the strobe. The replacement counter and any instruction-buffer refill update at that same edge. A written entry is visible to a lookup strobed in the following cycle. The bench drives inputs on the falling edge and holds the strobe for one rising edge. It then samples the outputs and the counter at the next falling edge, which is half a cycle after the expected update. Each write task ends before the next lookup task starts, so every check looks at exactly one clocked update.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int ASID_W = 8;
    localparam int VPN_W  = 22;   // virtual bits 31:10
    localparam int PPN_W  = 19;   // physical bits 28:10
    localparam int PA_W   = 29;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        logic [1:0]        size;
        logic              shared;
        logic              dirty;
        logic [1:0]        prot;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        PK_OK    = 2'd0,
        PK_PROT  = 2'd1,
        PK_INITW = 2'd2
    } perm_kind_e;

    typedef enum logic [11:0] {
        XC_NONE    = 12'h000,
        XC_MISS_RD = 12'h040,
        XC_MISS_WR = 12'h060,
        XC_INITW   = 12'h080,
        XC_PROT_RD = 12'h0A0,
        XC_PROT_WR = 12'h0C0
    } xcode_e;

    // Which of the virtual page bits 31:10 take part in the compare.
    function automatic logic [VPN_W-1:0] vpn_mask(input logic [1:0] size);
        case (size)
            2'd0:    vpn_mask = 22'h3FFFFF;
            2'd1:    vpn_mask = 22'h3FFFFC;
            2'd2:    vpn_mask = 22'h3FFFC0;
            default: vpn_mask = 22'h3FFC00;
        endcase
    endfunction

endpackage

// File: rtl/tlb_bank.sv
module tlb_bank
    import tlbx_pkg::*;
#(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IW-1:0]     widx,
    input  tlb_ent_t          went,
    input  logic              rf_we,
    input  logic [IW-1:0]     rf_idx,
    input  tlb_ent_t          rf_ent,
    input  logic [31:0]       va,
    input  logic [ASID_W-1:0] asid,
    input  logic              asid_bypass,
    output logic              hit,
    output tlb_ent_t          hit_ent
);

    tlb_ent_t         ents [N];
    logic [N-1:0]     hitv;
    logic [IW-1:0]    sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ents[i].valid <= 1'b0;
        end else begin
            if (rf_we) ents[rf_idx] <= rf_ent;
            if (we)    ents[widx]   <= went;   // explicit writes win
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic [VPN_W-1:0] m;
        logic             page_eq;
        logic             asid_ok;
        assign m       = vpn_mask(ents[g].size);
        assign page_eq = ((ents[g].vpn ^ va[31:10]) & m) == '0;
        assign asid_ok = ents[g].shared || asid_bypass || (ents[g].asid == asid);
        assign hitv[g] = ents[g].valid && page_eq && asid_ok;
    end

    // Lowest index wins.
    always_comb begin
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hitv[i]) sel = IW'(i);
        end
    end

    assign hit     = |hitv;
    assign hit_ent = ents[sel];

endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlbx_pkg::*;
(
    input  logic       instr,
    input  logic       write,
    input  logic       priv,
    input  logic [1:0] prot,
    input  logic       dirty,
    output perm_kind_e kind,
    output logic       grant_rw
);

    always_comb begin
        kind     = PK_OK;
        grant_rw = 1'b0;
        if (instr) begin
            if (!priv && !prot[1]) kind = PK_PROT;
        end else if (!priv && !prot[1]) begin
            kind = PK_PROT;                       // user codes 0,1
        end else if (!prot[0]) begin
            if (write) kind = PK_PROT;            // read-only page
        end else if (write && !dirty) begin
            kind = PK_INITW;                      // first write trap
        end else begin
            grant_rw = dirty;
        end
    end

endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
    parameter int N  = 64,
    localparam int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] bound,
    output logic [W-1:0] cnt
);

    logic [W:0] nxt;
    logic       wrap;

    assign nxt  = {1'b0, cnt} + 1'b1;
    assign wrap = (nxt >= (W+1)'(N)) || ((bound != '0) && (nxt == {1'b0, bound}));

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (step) cnt <= wrap ? '0 : nxt[W-1:0];
    end

endmodule

// File: rtl/tlb_xlate_unit.sv
module tlb_xlate_unit
    import tlbx_pkg::*;
#(
    parameter int N_ITLB = 4,
    parameter int N_UTLB = 64,
    localparam int UIW = $clog2(N_UTLB),
    localparam int IIW = (N_ITLB > 1) ? $clog2(N_ITLB) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [31:0]      req_vaddr,
    input  logic             req_write,
    input  logic             req_instr,
    input  logic             req_priv,
    input  logic [7:0]       req_asid,
    input  logic             req_sv,
    input  logic             req_probe,
    input  logic [UIW-1:0]   rep_bound,
    input  logic             wr_en,
    input  logic             wr_itlb,
    input  logic [UIW-1:0]   wr_idx,
    input  logic [21:0]      wr_vpn,
    input  logic [7:0]       wr_asid,
    input  logic [18:0]      wr_ppn,
    input  logic             wr_valid,
    input  logic [1:0]       wr_size,
    input  logic             wr_shared,
    input  logic             wr_dirty,
    input  logic [1:0]       wr_prot,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_rw,
    output logic             rsp_fault,
    output logic [11:0]      rsp_code,
    output logic [UIW-1:0]   rep_count
);

    tlb_ent_t   went, i_ent, u_ent, ent;
    logic       i_hit, u_hit, use_i, any_hit, bypass, refill;
    logic [IIW-1:0] slot;
    perm_kind_e pkind;
    logic       grant;
    logic [31:0] pmask, pa_full;
    logic [PA_W-1:0] pa_c;
    logic        rw_c, fault_c;
    xcode_e      code_c;

    assign went = '{valid: wr_valid, vpn: wr_vpn, asid: wr_asid, ppn: wr_ppn,
                    size: wr_size, shared: wr_shared, dirty: wr_dirty, prot: wr_prot};
    assign bypass = req_sv && req_priv;

    // Free-running slot pointer for instruction-buffer refills.
    always_ff @(posedge clk) begin
        if (rst) slot <= '0;
        else     slot <= slot + 1'b1;
    end

    assign refill = req_valid && req_instr && !i_hit && u_hit;

    tlb_bank #(.N(N_ITLB)) u_itlb (
        .clk(clk), .rst(rst),
        .we(wr_en && wr_itlb), .widx(wr_idx[IIW-1:0]), .went(went),
        .rf_we(refill), .rf_idx(slot), .rf_ent(u_ent),
        .va(req_vaddr), .asid(req_asid), .asid_bypass(bypass),
        .hit(i_hit), .hit_ent(i_ent)
    );

    tlb_bank #(.N(N_UTLB)) u_utlb (
        .clk(clk), .rst(rst),
        .we(wr_en && !wr_itlb), .widx(wr_idx), .went(went),
        .rf_we(1'b0), .rf_idx('0), .rf_ent(went),
        .va(req_vaddr), .asid(req_asid), .asid_bypass(bypass),
        .hit(u_hit), .hit_ent(u_ent)
    );

    assign use_i   = req_instr && i_hit;
    assign ent     = use_i ? i_ent : u_ent;
    assign any_hit = use_i || u_hit;

    tlb_perm u_perm (
        .instr(req_instr), .write(req_write), .priv(req_priv),
        .prot(ent.prot), .dirty(ent.dirty),
        .kind(pkind), .grant_rw(grant)
    );

    assign pmask   = {vpn_mask(ent.size), 10'b0};
    assign pa_full = (req_vaddr & ~pmask) | ({3'b0, ent.ppn, 10'b0} & pmask);

    always_comb begin
        code_c = XC_NONE;
        rw_c   = 1'b0;
        pa_c   = '0;
        if (!any_hit) begin
            code_c = req_write ? XC_MISS_WR : XC_MISS_RD;
        end else begin
            case (pkind)
                PK_OK: begin
                    pa_c = pa_full[PA_W-1:0];
                    rw_c = grant;
                end
                PK_PROT:  code_c = req_write ? XC_PROT_WR : XC_PROT_RD;
                default:  code_c = XC_INITW;
            endcase
        end
        fault_c = (code_c != XC_NONE);
        if (req_probe && fault_c) begin
            code_c  = XC_NONE;
            fault_c = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_rw    <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_code  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_paddr <= pa_c;
                rsp_rw    <= rw_c;
                rsp_fault <= fault_c;
                rsp_code  <= code_c;
            end
        end
    end

    tlb_repl #(.N(N_UTLB)) u_repl (
        .clk(clk), .rst(rst),
        .step(req_valid && !req_probe),
        .bound(rep_bound),
        .cnt(rep_count)
    );

endmodule

// File: rtl/tlbx_chk.sv
module tlbx_chk #(
    parameter int N_U = 64,
    localparam int W = $clog2(N_U)
) (
    input logic         clk,
    input logic         rst,
    input logic         req_valid,
    input logic         req_probe,
    input logic [W-1:0] rep_bound,
    input logic         rsp_valid,
    input logic         rsp_rw,
    input logic         rsp_fault,
    input logic [11:0]  rsp_code,
    input logic [W-1:0] rep_count
);

    p_lat_r13: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_idle_r13: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_probe_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_probe) |=> !rsp_fault);

    p_probe_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_probe) |=> $stable(rep_count));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(rep_count));

    p_bound_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_probe && rep_bound != '0 &&
         ({1'b0, rep_count} + 1'b1) == {1'b0, rep_bound}) |=> (rep_count == '0));

    p_code_set_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_code == 12'h040 || rsp_code == 12'h060 ||
                       rsp_code == 12'h080 || rsp_code == 12'h0A0 ||
                       rsp_code == 12'h0C0));

    p_grant_excl_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_rw |-> !rsp_fault);

endmodule

bind tlb_xlate_unit tlbx_chk #(.N_U(N_UTLB)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_probe(req_probe),
    .rep_bound(rep_bound), .rsp_valid(rsp_valid), .rsp_rw(rsp_rw),
    .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rep_count(rep_count)
);

// File: tb/tb_tlb_xlate_unit.sv
module tb_tlb_xlate_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0, req_write = 0, req_instr = 0, req_priv = 0;
    logic        req_sv = 0, req_probe = 0;
    logic [31:0] req_vaddr = '0;
    logic [7:0]  req_asid = '0;
    logic [5:0]  rep_bound = '0;
    logic        wr_en = 0, wr_itlb = 0, wr_valid = 0, wr_shared = 0, wr_dirty = 0;
    logic [5:0]  wr_idx = '0;
    logic [21:0] wr_vpn = '0;
    logic [7:0]  wr_asid = '0;
    logic [18:0] wr_ppn = '0;
    logic [1:0]  wr_size = '0, wr_prot = '0;
    logic        rsp_valid, rsp_rw, rsp_fault;
    logic [28:0] rsp_paddr;
    logic [11:0] rsp_code;
    logic [5:0]  rep_count;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int exp_rc = 0;

    always #2.5 clk = ~clk;

    tlb_xlate_unit dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_instr(req_instr), .req_priv(req_priv),
        .req_asid(req_asid), .req_sv(req_sv), .req_probe(req_probe),
        .rep_bound(rep_bound), .wr_en(wr_en), .wr_itlb(wr_itlb), .wr_idx(wr_idx),
        .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_ppn(wr_ppn), .wr_valid(wr_valid),
        .wr_size(wr_size), .wr_shared(wr_shared), .wr_dirty(wr_dirty),
        .wr_prot(wr_prot), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_rw(rsp_rw), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
        .rep_count(rep_count)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic put(input bit itl, input int idx, input logic [31:0] vtag,
                       input logic [7:0] asid, input logic [31:0] pbase, input bit v,
                       input logic [1:0] sz, input bit sh, input bit d, input logic [1:0] pr);
        @(negedge clk);
        wr_en = 1; wr_itlb = itl; wr_idx = idx[5:0]; wr_vpn = vtag[31:10];
        wr_asid = asid; wr_ppn = pbase[28:10]; wr_valid = v; wr_size = sz;
        wr_shared = sh; wr_dirty = d; wr_prot = pr;
        @(negedge clk);
        wr_en = 0;
    endtask

    // One lookup; result sampled half a cycle after the capturing edge.
    task automatic lookup(input logic [31:0] va, input bit w, input bit ins, input bit pv,
                          input logic [7:0] asid, input bit sv, input bit pb);
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_write = w; req_instr = ins;
        req_priv = pv; req_asid = asid; req_sv = sv; req_probe = pb;
        @(negedge clk);
        req_valid = 0;
        if (!pb) exp_rc = (exp_rc + 1 >= 64 || (rep_bound != 0 && exp_rc + 1 == int'(rep_bound)))
                          ? 0 : exp_rc + 1;
        chk("R13 rsp_valid", {31'b0, rsp_valid}, 32'd1);
        chk("R9 R10 rep_count", {26'b0, rep_count}, exp_rc);
    endtask

    task automatic exp_ok(input string what, input logic [31:0] pa, input bit rw);
        chk({what, " paddr"}, {3'b0, rsp_paddr}, pa);
        chk({what, " grant"}, {31'b0, rsp_rw}, {31'b0, rw});
        chk({what, " fault"}, {31'b0, rsp_fault}, 32'd0);
    endtask

    task automatic exp_flt(input string what, input logic [11:0] code);
        chk({what, " code"}, {20'b0, rsp_code}, {20'b0, code});
        chk({what, " fault"}, {31'b0, rsp_fault}, 32'd1);
        chk({what, " paddr"}, {3'b0, rsp_paddr}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R13 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R9 reset rep_count", {26'b0, rep_count}, 32'd0);
        lookup(32'h0000_1000, 0, 0, 1, 8'd0, 0, 0);
        exp_flt("R13 R11 empty read miss", 12'h040);
        lookup(32'h0000_1000, 1, 0, 1, 8'd0, 0, 0);
        exp_flt("R11 empty write miss", 12'h060);
    endtask

    task automatic t_sizes();
        put(0, 0, 32'h1234_5000, 8'd5, 32'h0ABC_D000, 1, 2'd1, 1, 1, 2'd3);
        lookup(32'h1234_5ABC, 0, 0, 1, 8'd0, 0, 0);
        exp_ok("R1 R3 4K hit", 32'h0ABC_DABC, 1);
        lookup(32'h1234_6000, 0, 0, 1, 8'd0, 0, 0);
        exp_flt("R1 4K next page miss", 12'h040);
        put(0, 1, 32'h2000_0400, 8'd0, 32'h0300_0400, 1, 2'd0, 1, 1, 2'd3);
        lookup(32'h2000_0404, 0, 0, 1, 8'd0, 0, 0);
        exp_ok("R1 1K hit", 32'h0300_0404, 1);
        lookup(32'h2000_0800, 0, 0, 1, 8'd0, 0, 0);
        exp_flt("R1 1K neighbour miss", 12'h040);
        put(0, 2, 32'h3001_0000, 8'd0, 32'h0402_0000, 1, 2'd2, 1, 1, 2'd3);
        lookup(32'h3001_ABCD, 0, 0, 1, 8'd0, 0, 0);
        exp_ok("R1 64K hit", 32'h0402_ABCD, 1);
        put(0, 3, 32'h4010_0000, 8'd0, 32'hFFF0_0000, 1, 2'd3, 1, 1, 2'd3);
        lookup(32'h401A_BCDE, 0, 0, 1, 8'd0, 0, 0);
        exp_ok("R1 R3 1M hit clipped", 32'h1FFA_BCDE, 1);
        put(0, 4, 32'h5000_0000, 8'd0, 32'h0100_0000, 0, 2'd1, 1, 1, 2'd3);
        lookup(32'h5000_0000, 0, 0, 1, 8'd0, 0, 0);
        exp_flt("R1 invalid entry miss", 12'h040);
    endtask

    task automatic t_asid();
        put(0, 5, 32'h6000_0000, 8'd7, 32'h0060_0000, 1, 2'd1, 0, 1, 2'd3);
        lookup(32'h6000_0010, 0, 0, 0, 8'd7, 0, 0);
        exp_ok("R2 asid equal", 32'h0060_0010, 1);
        lookup(32'h6000_0010, 0, 0, 0, 8'd8, 0, 0);
        exp_flt("R2 asid differs", 12'h040);
        lookup(32'h6000_0010, 0, 0, 1, 8'd8, 1, 0);
        exp_ok("R2 single-virtual priv bypass", 32'h0060_0010, 1);
        lookup(32'h6000_0010, 0, 0, 1, 8'd8, 0, 0);
        exp_flt("R2 priv without sv", 12'h040);
        lookup(32'h6000_0010, 0, 0, 0, 8'd8, 1, 0);
        exp_flt("R2 user with sv", 12'h040);
    endtask

    task automatic t_order();
        put(0, 6, 32'h7000_0000, 8'd0, 32'h0011_1000, 1, 2'd1, 1, 1, 2'd3);
        put(0, 7, 32'h7000_0000, 8'd0, 32'h0022_2000, 1, 2'd1, 1, 1, 2'd3);
        put(1, 0, 32'h7000_0000, 8'd0, 32'h0033_3000, 1, 2'd1, 1, 1, 2'd3);
        lookup(32'h7000_0010, 0, 0, 1, 8'd0, 0, 0);
        exp_ok("R4 data lowest index", 32'h0011_1010, 1);
        lookup(32'h7000_0010, 0, 1, 1, 8'd0, 0, 0);
        exp_ok("R4 R6 fetch prefers itlb", 32'h0033_3010, 0);
    endtask

    task automatic t_refill();
        put(0, 8, 32'h0A00_0000, 8'd0, 32'h0055_5000, 1, 2'd1, 1, 0, 2'd2);
        lookup(32'h0A00_0020, 0, 1, 1, 8'd0, 0, 0);
        exp_ok("R5 fetch via unified", 32'h0055_5020, 0);
        put(0, 8, 32'h0A00_0000, 8'd0, 32'h0055_5000, 0, 2'd1, 1, 0, 2'd2);
        lookup(32'h0A00_0020, 0, 0, 1, 8'd0, 0, 0);
        exp_flt("R5 R4 data misses after invalidate", 12'h040);
        lookup(32'h0A00_0020, 0, 1, 1, 8'd0, 0, 0);
        exp_ok("R5 refilled copy used", 32'h0055_5020, 0);
    endtask

    task automatic t_iperm();
        put(0, 9, 32'h0B00_0000, 8'd0, 32'h00B0_0000, 1, 2'd1, 1, 1, 2'd1);
        lookup(32'h0B00_0004, 0, 1, 0, 8'd0, 0, 0);
        exp_flt("R6 user fetch prot1 clear", 12'h0A0);
        lookup(32'h0B00_0004, 0, 1, 1, 8'd0, 0, 0);
        exp_ok("R6 priv fetch passes", 32'h00B0_0004, 0);
        put(0, 10, 32'h0C00_0000, 8'd0, 32'h00C0_0000, 1, 2'd1, 1, 1, 2'd2);
        lookup(32'h0C00_0008, 0, 1, 0, 8'd0, 0, 0);
        exp_ok("R6 user fetch prot1 set", 32'h00C0_0008, 0);
    endtask

    task automatic t_pdata();
        put(0, 11, 32'h0D00_0000, 8'd0, 32'h0100_B000, 1, 2'd1, 1, 0, 2'd0);
        put(0, 12, 32'h0E00_0000, 8'd0, 32'h0100_C000, 1, 2'd1, 1, 0, 2'd1);
        put(0, 13, 32'h0F00_0000, 8'd0, 32'h0100_D000, 1, 2'd1, 1, 1, 2'd1);
        put(0, 14, 32'h1000_0000, 8'd0, 32'h0100_E000, 1, 2'd1, 1, 1, 2'd2);
        lookup(32'h0D00_0010, 0, 0, 1, 8'd0, 0, 0);
        exp_ok("R7 code0 read", 32'h0100_B010, 0);
        lookup(32'h0D00_0010, 1, 0, 1, 8'd0, 0, 0);
        exp_flt("R7 R11 code0 write", 12'h0C0);
        lookup(32'h1000_0010, 0, 0, 1, 8'd0, 0, 0);
        exp_ok("R7 code2 read dirty", 32'h0100_E010, 0);
        lookup(32'h1000_0010, 1, 0, 1, 8'd0, 0, 0);
        exp_flt("R7 code2 write", 12'h0C0);
        lookup(32'h0E00_0010, 0, 0, 1, 8'd0, 0, 0);
        exp_ok("R7 code1 clean read", 32'h0100_C010, 0);
        lookup(32'h0E00_0010, 1, 0, 1, 8'd0, 0, 0);
        exp_flt("R7 R11 code1 clean write", 12'h080);
        lookup(32'h0F00_0010, 1, 0, 1, 8'd0, 0, 0);
        exp_ok("R7 code1 dirty write", 32'h0100_D010, 1);
    endtask

    task automatic t_udata();
        put(0, 15, 32'h1100_0000, 8'd0, 32'h0100_F000, 1, 2'd1, 1, 0, 2'd3);
        lookup(32'h0D00_0010, 0, 0, 0, 8'd0, 0, 0);
        exp_flt("R8 R11 user code0 read", 12'h0A0);
        lookup(32'h0F00_0010, 0, 0, 0, 8'd0, 0, 0);
        exp_flt("R8 user code1 read", 12'h0A0);
        lookup(32'h1000_0010, 0, 0, 0, 8'd0, 0, 0);
        exp_ok("R8 user code2 read", 32'h0100_E010, 0);
        lookup(32'h1000_0010, 1, 0, 0, 8'd0, 0, 0);
        exp_flt("R8 user code2 write", 12'h0C0);
        lookup(32'h1100_0010, 0, 0, 0, 8'd0, 0, 0);
        exp_ok("R8 user code3 clean read", 32'h0100_F010, 0);
        lookup(32'h1100_0010, 1, 0, 0, 8'd0, 0, 0);
        exp_flt("R8 user code3 clean write", 12'h080);
        lookup(32'h1234_5010, 1, 0, 0, 8'd0, 0, 0);
        exp_ok("R8 user code3 dirty write", 32'h0ABC_D010, 1);
    endtask

    task automatic t_probe();
        lookup(32'h5000_0000, 1, 0, 1, 8'd0, 0, 1);
        chk("R12 probe miss fault", {31'b0, rsp_fault}, 32'd0);
        chk("R12 probe miss code", {20'b0, rsp_code}, 32'd0);
        chk("R12 probe miss paddr", {3'b0, rsp_paddr}, 32'd0);
        lookup(32'h0D00_0010, 0, 0, 0, 8'd0, 0, 1);
        chk("R12 probe violation fault", {31'b0, rsp_fault}, 32'd0);
        lookup(32'h1234_5ABC, 0, 0, 1, 8'd0, 0, 1);
        exp_ok("R12 probe hit", 32'h0ABC_DABC, 1);
    endtask

    task automatic t_counter();
        rep_bound = 6'd0;
        for (int k = 0; k < 70; k++) lookup(32'h5000_0000, 0, 0, 1, 8'd0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R9 counter holds idle", {26'b0, rep_count}, exp_rc);
        rep_bound = 6'd5;
        while (exp_rc != 4) lookup(32'h5000_0000, 0, 0, 1, 8'd0, 0, 0);
        lookup(32'h5000_0000, 0, 0, 1, 8'd0, 0, 0);
        chk("R10 boundary wrap", {26'b0, rep_count}, 32'd0);
        for (int k = 0; k < 8; k++) lookup(32'h5000_0000, 0, 0, 1, 8'd0, 0, 0);
        rep_bound = 6'd0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_sizes();
        t_asid();
        t_order();
        t_refill();
        t_iperm();
        t_pdata();
        t_udata();
        t_probe();
        t_counter();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL R13 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule